// File: doc/BRIEF.md
# Fault Capture Register with Attention Classification

This block collects error pulses from up to 64 hardware sources into a sticky capture register. A bit, once set, stays set until software clears it. Each bit has its own mask bit and a two-bit action code. Together these route an unmasked captured bit to one of four registered attention lines: checkstop, recoverable, unit-checkstop or special.

Software reaches the capture, mask and two action registers through a small register port with an eight-word local window. Besides plain writes, the window has alias offsets that AND write data into the capture register or into the mask, and an alias that ORs data into the mask. Software can therefore clear a single captured bit, or set a single mask bit, in one write without a read-modify-write. A read returns the addressed register one cycle later.

Top module: `fault_isolation_reg`

## Requirements
- R1: After reset the capture register and both action registers read zero, the mask reads all ones, all four attention outputs are low and `rvalid_o` is low.
- R2: An `err_i` bit that is high at a rising clock edge sets the matching capture bit from that edge on. The bit stays set while `err_i` returns low and until software clears it.
- R3: The action code of a bit is {ACT0, ACT1}. An unmasked set capture bit drives `attn_chk_o` for code 00, `attn_rec_o` for 01, `attn_spc_o` for 10 and `attn_ucs_o` for 11. The attention output rises on the clock edge after the capture bit becomes visible and falls on the edge after the last such bit is cleared.
- R4: A set mask bit keeps its capture bit away from every attention output. The capture bit is still latched and can still be read.
- R5: A write at offset 0 replaces the capture register. A write at offset 1 ANDs the data into it, so a zero data bit clears that bit and a one data bit leaves it unchanged.
- R6: A write at offset 3 replaces the mask, a write at offset 4 ANDs the data into the mask, and a write at offset 5 ORs the data into the mask.
- R7: A write at offset 6 loads ACT0 and a write at offset 7 loads ACT1. Both read back unchanged at the same offsets.
- R8: When an error pulse and a clearing write hit the same capture bit in the same cycle, the bit ends up set.
- R9: A read at a rising edge gives `rvalid_o` high and `rdata_o` holding the register contents from before that edge on the following cycle. Offsets 0 and 1 return the capture register, offsets 3, 4 and 5 return the mask, and offset 2 reads zero. A write to offset 2 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_i | input | 64 | Error pulses, one per source |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word offset inside the register window |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| attn_chk_o | output | 1 | Checkstop attention (code 00) |
| attn_rec_o | output | 1 | Recoverable attention (code 01) |
| attn_spc_o | output | 1 | Special attention (code 10) |
| attn_ucs_o | output | 1 | Unit-checkstop attention (code 11) |

## Verification
An error pulse sampled at one rising edge is visible in the capture register after that edge. The matching attention line follows one edge later, and read data and `rvalid_o` arrive on the edge after the read strobe. The bench reference model updates on the rising edge with the same register depth. Inputs are driven and outputs compared on the falling edge, so every comparison samples a settled result in the cycle it is due. The directed checks wait exactly those one or two edges before reading the attention lines or the returned data.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int unsigned OFS_W   = 3;
    localparam int unsigned N_CLASS = 4;

    // word offsets inside the register window
    typedef enum logic [OFS_W-1:0] {
        OFS_FIR      = 3'd0,
        OFS_FIR_AND  = 3'd1,
        OFS_HOLE     = 3'd2,
        OFS_MASK     = 3'd3,
        OFS_MASK_AND = 3'd4,
        OFS_MASK_OR  = 3'd5,
        OFS_ACT0     = 3'd6,
        OFS_ACT1     = 3'd7
    } ofs_e;

    // attention class, encoded as {act0, act1}
    typedef enum logic [1:0] {
        CLS_CHK = 2'b00,
        CLS_REC = 2'b01,
        CLS_SPC = 2'b10,
        CLS_UCS = 2'b11
    } cls_e;

endpackage

// File: rtl/fcr_regs.sv
module fcr_regs
    import fcr_pkg::*;
#(
    parameter int unsigned W        = 64,
    parameter logic [W-1:0] MASK_RST = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         err_i,
    input  logic                 wr_i,
    input  logic [OFS_W-1:0]     addr_i,
    input  logic [W-1:0]         wdata_i,
    output logic [W-1:0]         fir_o,
    output logic [W-1:0]         mask_o,
    output logic [W-1:0]         act0_o,
    output logic [W-1:0]         act1_o
);

    typedef struct packed {
        logic [W-1:0] fir;
        logic [W-1:0] mask;
        logic [W-1:0] act0;
        logic [W-1:0] act1;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (ofs_e'(addr_i))
                OFS_FIR:      st_d.fir  = wdata_i;
                OFS_FIR_AND:  st_d.fir  = st_q.fir & wdata_i;
                OFS_MASK:     st_d.mask = wdata_i;
                OFS_MASK_AND: st_d.mask = st_q.mask & wdata_i;
                OFS_MASK_OR:  st_d.mask = st_q.mask | wdata_i;
                OFS_ACT0:     st_d.act0 = wdata_i;
                OFS_ACT1:     st_d.act1 = wdata_i;
                default:      st_d = st_q;
            endcase
        end
        // incoming errors are merged last so they win over any clear
        st_d.fir = st_d.fir | err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fir: '0, mask: MASK_RST, act0: '0, act1: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fir_o  = st_q.fir;
    assign mask_o = st_q.mask;
    assign act0_o = st_q.act0;
    assign act1_o = st_q.act1;

endmodule

// File: rtl/fcr_readout.sv
module fcr_readout
    import fcr_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [W-1:0]     fir_i,
    input  logic [W-1:0]     mask_i,
    input  logic [W-1:0]     act0_i,
    input  logic [W-1:0]     act1_i,
    output logic [W-1:0]     rdata_o,
    output logic             rvalid_o
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd_i;
        if (rd_i) begin
            case (ofs_e'(addr_i))
                OFS_FIR, OFS_FIR_AND:                rd_d.dat = fir_i;
                OFS_MASK, OFS_MASK_AND, OFS_MASK_OR: rd_d.dat = mask_i;
                OFS_ACT0:                            rd_d.dat = act0_i;
                OFS_ACT1:                            rd_d.dat = act1_i;
                default:                             rd_d.dat = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o  = rd_q.dat;
    assign rvalid_o = rd_q.vld;

endmodule

// File: rtl/fcr_classify.sv
module fcr_classify
    import fcr_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fir_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] act0_i,
    input  logic [W-1:0] act1_i,
    output logic         chk_o,
    output logic         rec_o,
    output logic         spc_o,
    output logic         ucs_o
);

    localparam int unsigned NC = N_CLASS;

    logic [W-1:0]  live;
    logic [NC-1:0] hit;

    assign live = fir_i & ~mask_i;

    for (genvar c = 0; c < NC; c++) begin : g_cls
        localparam logic [1:0] CODE = 2'(c);
        logic [W-1:0] sel;
        assign sel    = (CODE[1] ? act0_i : ~act0_i) & (CODE[0] ? act1_i : ~act1_i);
        assign hit[c] = |(live & sel);
    end

    typedef struct packed {
        logic chk;
        logic rec;
        logic spc;
        logic ucs;
    } attn_t;

    attn_t at_d, at_q;

    always_comb begin
        at_d.chk = hit[CLS_CHK];
        at_d.rec = hit[CLS_REC];
        at_d.spc = hit[CLS_SPC];
        at_d.ucs = hit[CLS_UCS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            at_q <= '0;
        end else begin
            at_q <= at_d;
        end
    end

    assign chk_o = at_q.chk;
    assign rec_o = at_q.rec;
    assign spc_o = at_q.spc;
    assign ucs_o = at_q.ucs;

endmodule

// File: rtl/fault_isolation_reg.sv
module fault_isolation_reg
    import fcr_pkg::*;
#(
    parameter int unsigned  W        = 64,
    parameter logic [W-1:0] MASK_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     err_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    output logic             rvalid_o,
    output logic             attn_chk_o,
    output logic             attn_rec_o,
    output logic             attn_spc_o,
    output logic             attn_ucs_o
);

    logic [W-1:0] fir_w, mask_w, act0_w, act1_w;

    fcr_regs #(.W(W), .MASK_RST(MASK_RST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_i   (err_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .fir_o   (fir_w),
        .mask_o  (mask_w),
        .act0_o  (act0_w),
        .act1_o  (act1_w)
    );

    fcr_readout #(.W(W)) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .fir_i    (fir_w),
        .mask_i   (mask_w),
        .act0_i   (act0_w),
        .act1_i   (act1_w),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    fcr_classify #(.W(W)) u_classify (
        .clk    (clk),
        .rst_n  (rst_n),
        .fir_i  (fir_w),
        .mask_i (mask_w),
        .act0_i (act0_w),
        .act1_i (act1_w),
        .chk_o  (attn_chk_o),
        .rec_o  (attn_rec_o),
        .spc_o  (attn_spc_o),
        .ucs_o  (attn_ucs_o)
    );

endmodule

// File: rtl/fault_isolation_reg_chk.sv
module fault_isolation_reg_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] err_i,
    input logic         wr_i,
    input logic         rd_i,
    input logic [2:0]   addr_i,
    input logic [W-1:0] wdata_i,
    input logic [W-1:0] fir_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] act0_q,
    input logic [W-1:0] act1_q,
    input logic         rvalid_o,
    input logic         attn_chk_o,
    input logic         attn_rec_o,
    input logic         attn_spc_o,
    input logic         attn_ucs_o
);

    // high once at least one edge has been taken out of reset
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2: every error seen at the last edge is now held in the capture register
    a_r2_err_captured: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((fir_q & $past(err_i)) == $past(err_i)));

    // R8: after an AND-clear, the cleared bits hold exactly the errors of that cycle
    a_r8_err_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wr_i) && ($past(addr_i) == 3'd1))
        |-> ((fir_q & ~$past(wdata_i)) == ($past(err_i) & ~$past(wdata_i))));

    // R4: nothing unmasked captured means every attention line is low next cycle
    a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((fir_q & ~mask_q) == '0)
        |=> !(attn_chk_o || attn_rec_o || attn_spc_o || attn_ucs_o));

    // R3: an unmasked bit with code 11 raises the unit-checkstop line next cycle
    a_r3_ucs_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fir_q & ~mask_q & act0_q & act1_q)) |=> attn_ucs_o);

    // R6: an OR write into the mask leaves every data one set in the mask
    a_r6_mask_or_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == 3'd5)) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R9: read strobe gives valid data on the next cycle, and only then
    a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);
    a_r9_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);

endmodule

bind fault_isolation_reg fault_isolation_reg_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (err_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .fir_q      (fir_w),
    .mask_q     (mask_w),
    .act0_q     (act0_w),
    .act1_q     (act1_w),
    .rvalid_o   (rvalid_o),
    .attn_chk_o (attn_chk_o),
    .attn_rec_o (attn_rec_o),
    .attn_spc_o (attn_spc_o),
    .attn_ucs_o (attn_ucs_o)
);

// File: tb/fault_isolation_reg_tb_top.sv
module fault_isolation_reg_tb_top;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] err_i = '0;
    logic         wr_i = 1'b0;
    logic         rd_i = 1'b0;
    logic [2:0]   addr_i = '0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic         rvalid_o;
    logic         attn_chk_o, attn_rec_o, attn_spc_o, attn_ucs_o;

    always #10 clk = ~clk;   // 50 MHz

    fault_isolation_reg #(.W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_i      (err_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o),
        .attn_chk_o (attn_chk_o),
        .attn_rec_o (attn_rec_o),
        .attn_spc_o (attn_spc_o),
        .attn_ucs_o (attn_ucs_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [W-1:0] m_fir, m_mask, m_a0, m_a1, m_rdata;
    logic         m_rvalid, m_chk, m_rec, m_spc, m_ucs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fir = '0; m_mask = '1; m_a0 = '0; m_a1 = '0;
            m_rdata = '0; m_rvalid = 1'b0;
            m_chk = 0; m_rec = 0; m_spc = 0; m_ucs = 0;
        end else begin
            m_chk = 0; m_rec = 0; m_spc = 0; m_ucs = 0;
            for (int i = 0; i < W; i++) begin
                if (m_fir[i] && !m_mask[i]) begin
                    if (!m_a0[i] && !m_a1[i])      m_chk = 1;
                    else if (!m_a0[i] && m_a1[i])  m_rec = 1;
                    else if (m_a0[i] && !m_a1[i])  m_spc = 1;
                    else                           m_ucs = 1;
                end
            end
            m_rvalid = rd_i;
            if (rd_i) begin
                if (addr_i <= 3'd1)      m_rdata = m_fir;
                else if (addr_i == 3'd2) m_rdata = '0;
                else if (addr_i <= 3'd5) m_rdata = m_mask;
                else if (addr_i == 3'd6) m_rdata = m_a0;
                else                     m_rdata = m_a1;
            end
            if (wr_i) begin
                if (addr_i == 3'd0)      m_fir  = wdata_i;
                else if (addr_i == 3'd1) m_fir  = m_fir & wdata_i;
                else if (addr_i == 3'd3) m_mask = wdata_i;
                else if (addr_i == 3'd4) m_mask = m_mask & wdata_i;
                else if (addr_i == 3'd5) m_mask = m_mask | wdata_i;
                else if (addr_i == 3'd6) m_a0   = wdata_i;
                else if (addr_i == 3'd7) m_a1   = wdata_i;
            end
            m_fir = m_fir | err_i;
        end
    end

    task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("rvalid", W'(rvalid_o), W'(m_rvalid));
            chk("attention", W'({attn_chk_o, attn_rec_o, attn_spc_o, attn_ucs_o}),
                W'({m_chk, m_rec, m_spc, m_ucs}));
            if (m_rvalid) chk("rdata", rdata_o, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic op_wr(logic [2:0] a, logic [W-1:0] d);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd_exp(logic [2:0] a, logic [W-1:0] exp, string what);
        rd_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_i = 1'b0;
        chk(what, rdata_o, exp);
    endtask

    task automatic pulse(logic [W-1:0] e);
        err_i = e;
        @(negedge clk);
        err_i = '0;
    endtask

    task automatic attn_exp(logic [3:0] exp, string what);
        chk(what, W'({attn_chk_o, attn_rec_o, attn_spc_o, attn_ucs_o}), W'(exp));
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        cur_req = "R1";
        attn_exp(4'b0000, "attention after reset");
        chk("rvalid after reset", W'(rvalid_o), '0);
        rd_exp(3'd3, '1, "mask reset");
        rd_exp(3'd0, '0, "capture reset");
        rd_exp(3'd6, '0, "act0 reset");
        rd_exp(3'd7, '0, "act1 reset");

        // R7 action registers
        cur_req = "R7";
        op_wr(3'd6, 64'h0123_4567_89AB_CDEF);
        op_wr(3'd7, 64'hFEDC_BA98_7654_3210);
        rd_exp(3'd6, 64'h0123_4567_89AB_CDEF, "act0 readback");
        rd_exp(3'd7, 64'hFEDC_BA98_7654_3210, "act1 readback");

        // R6 mask write, AND, OR
        cur_req = "R6";
        op_wr(3'd3, 64'hFF00_FF00_0000_FFFF);
        rd_exp(3'd3, 64'hFF00_FF00_0000_FFFF, "mask write");
        op_wr(3'd4, 64'h0F0F_0F0F_0F0F_0F0F);
        rd_exp(3'd4, 64'h0F00_0F00_0000_0F0F, "mask and");
        op_wr(3'd5, 64'h8000_0000_0000_0010);
        rd_exp(3'd5, 64'h8F00_0F00_0000_0F1F, "mask or");
        op_wr(3'd3, '0);

        // R3 classification: bit0 code00, bit1 01, bit2 10, bit3 11
        cur_req = "R3";
        op_wr(3'd6, 64'h0000_0000_0000_000C);
        op_wr(3'd7, 64'h0000_0000_0000_000A);
        for (int k = 0; k < 4; k++) begin
            pulse(W'(1) << k);
            @(negedge clk);
            attn_exp(4'b1000 >> k, "attention for one class");
            op_wr(3'd1, ~(W'(1) << k));
            @(negedge clk);
            attn_exp(4'b0000, "attention after clear");
        end
        pulse(64'h0000_0000_0000_000F);
        @(negedge clk);
        attn_exp(4'b1111, "all classes together");
        op_wr(3'd1, '0);
        @(negedge clk);

        // R2 sticky capture
        cur_req = "R2";
        pulse(64'h8000_0000_0000_0100);
        repeat (3) @(negedge clk);
        rd_exp(3'd0, 64'h8000_0000_0000_0100, "sticky capture");
        pulse(64'h0000_0001_0000_0000);
        rd_exp(3'd0, 64'h8000_0001_0000_0100, "accumulated capture");
        op_wr(3'd1, '0);

        // R4 mask blocks attention, bit stays readable
        cur_req = "R4";
        op_wr(3'd5, 64'h0000_0000_0000_0001);
        pulse(64'h0000_0000_0000_0001);
        repeat (2) @(negedge clk);
        attn_exp(4'b0000, "masked bit silent");
        rd_exp(3'd0, 64'h0000_0000_0000_0001, "masked bit readable");
        op_wr(3'd4, ~W'(1));
        @(negedge clk);
        attn_exp(4'b1000, "unmask raises checkstop");
        op_wr(3'd1, '0);
        @(negedge clk);

        // R8 error beats simultaneous clear
        cur_req = "R8";
        pulse(64'h0000_0000_0000_0020);
        wr_i = 1'b1; addr_i = 3'd1; wdata_i = '0; err_i = 64'h0000_0000_0000_0020;
        @(negedge clk);
        wr_i = 1'b0; err_i = '0;
        rd_exp(3'd0, 64'h0000_0000_0000_0020, "error wins over clear");

        // R5 direct write and AND alias
        cur_req = "R5";
        op_wr(3'd0, 64'h00F0_0000_0000_0F00);
        rd_exp(3'd1, 64'h00F0_0000_0000_0F00, "direct write");
        op_wr(3'd1, 64'hFFFF_FFFF_FFFF_F0FF);
        rd_exp(3'd0, 64'h00F0_0000_0000_0000, "and clear");
        op_wr(3'd0, '0);

        // R9 hole offset and read-before-write ordering
        cur_req = "R9";
        op_wr(3'd2, '1);
        rd_exp(3'd2, '0, "hole reads zero");
        rd_exp(3'd0, '0, "hole write left capture");
        rd_exp(3'd3, '0, "hole write left mask");
        rd_exp(3'd6, 64'h0000_0000_0000_000C, "hole write left act0");
        wr_i = 1'b1; rd_i = 1'b1; addr_i = 3'd6; wdata_i = 64'h55;
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0;
        chk("read returns old value", rdata_o, 64'h0000_0000_0000_000C);
        rd_exp(3'd6, 64'h55, "write then read");

        // mixed traffic checked against the model every cycle
        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            err_i   = (($urandom % 6) == 0) ? {$urandom, $urandom} & {$urandom, $urandom} : '0;
            wr_i    = (($urandom % 3) == 0);
            rd_i    = (($urandom % 2) == 0);
            addr_i  = 3'($urandom);
            wdata_i = {$urandom, $urandom};
            @(negedge clk);
        end
        err_i = '0; wr_i = 1'b0; rd_i = 1'b0;
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule